// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reconfiguration

This block is a watchdog. Its counter advances on ticks from a slow, separate oscillator. The tick arrives as an enable pulse sampled in the system clock domain. Software must pulse the restart strobe before the counter reaches the selected limit. If it does not, the block acts according to its mode:

- **Interrupt mode:** it raises an interrupt.
- **Reset mode:** it issues a one-cycle system reset pulse.
- **Combined mode:** it interrupts first. The interrupt drops the interrupt enable, so the next expiry resets the system. This gives software one period to save state before the reset.

The configuration is written through a single-cycle write port. The fields are an unlock request bit, a reset-enable bit, an interrupt-enable bit, a 4-bit period select and a write-one-to-clear strobe for the interrupt flag. Some changes need a short timed unlock first: clearing the reset enable, or changing the period. A static fuse input pins the block to reset mode.

Top module: `wdog_guard`

## Requirements
- R1: After reset, `irq`, `irq_flag` and `sys_rst` are 0. With `fuse_lock` low, `cfg_rst_en` and `cfg_irq_en` read 0 and `cfg_sel` reads 0.
- R2: Select code n (0..9) gives an expiry on the 2^(BASE_EXP+n)-th tick after a restart. Codes 10 to 15 behave as code 9 but read back as written.
- R3: `kick` clears the counter. When `kick` and `tick` are high in the same cycle, `kick` wins and the tick is not counted.
- R4: When the interrupt enable is set and the reset enable is clear, an expiry gives a one-cycle `irq` pulse in the cycle after the expiring tick. It also sets `irq_flag`. The counter restarts from zero, so expiries repeat every period. `irq` and `sys_rst` are never high together.
- R5: When the reset enable is set and the interrupt enable is clear, an expiry gives a one-cycle `sys_rst` pulse in the cycle after the expiring tick. The pulse leaves `irq_flag` unchanged.
- R6: When both enables are set, the first expiry gives `irq` and clears the interrupt enable in hardware. The following expiry then gives `sys_rst`.
- R7: A write with `wr_flag_clr`=1 clears `irq_flag`. If a new interrupt expiry occurs in the same cycle, the flag stays set.
- R8: A write with `wr_chg`=1 and `wr_rst_en`=1 opens an unlock window. A write with `wr_chg`=0 sampled in any of the next four cycles loads both `wr_rst_en` and `wr_sel`. That write also closes the window.
- R9: Outside an open window, a write cannot clear the reset enable and cannot change `cfg_sel`. Setting the reset enable, or writing the interrupt enable, takes effect on any write.
- R10: A write with `wr_chg`=0 sampled in the fifth cycle after the unlock write is treated as outside the window.
- R11: While `fuse_lock` is high:
  - `cfg_rst_en` reads 1 and `cfg_irq_en` reads 0, whatever is written.
  - An expiry gives `sys_rst` and never `irq`.
- R12: When neither enable is set, an expiry has no visible effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow-oscillator tick enable |
| kick | input | 1 | Restart strobe, clears the counter |
| fuse_lock | input | 1 | Static fuse, forces reset mode |
| wr_en | input | 1 | Configuration write strobe |
| wr_chg | input | 1 | Unlock request bit of the write |
| wr_rst_en | input | 1 | Reset-enable bit of the write |
| wr_irq_en | input | 1 | Interrupt-enable bit of the write |
| wr_sel | input | 4 | Period select of the write |
| wr_flag_clr | input | 1 | Write 1 to clear the interrupt flag |
| irq | output | 1 | One-cycle interrupt request |
| irq_flag | output | 1 | Sticky interrupt flag |
| sys_rst | output | 1 | One-cycle system reset request |
| cfg_rst_en | output | 1 | Effective reset enable |
| cfg_irq_en | output | 1 | Effective interrupt enable |
| cfg_sel | output | 4 | Stored period select |

## Verification
The in-RTL assertions check the following on every cycle:
- the reset pulse is one cycle wide;
- `irq` and `sys_rst` are exclusive;
- a kick suppresses any expiry in the next cycle;
- an interrupt under combined mode leaves the interrupt enable clear;
- the fuse never lets an interrupt through;
- the period select and the reset enable only fall or change out of an open unlock window.

The exact period length for every select code, the four-cycle edge of the window and the escalation from interrupt to reset are shown only by the bench's scenarios.

// File: rtl/wdog_guard.sv
`timescale 1ns/1ps
module wdog_guard #(
  parameter int BASE_EXP = 11,
  parameter int NUM_SEL  = 10,
  parameter int WIN_LEN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       kick,
  input  logic       fuse_lock,
  input  logic       wr_en,
  input  logic       wr_chg,
  input  logic       wr_rst_en,
  input  logic       wr_irq_en,
  input  logic [3:0] wr_sel,
  input  logic       wr_flag_clr,
  output logic       irq,
  output logic       irq_flag,
  output logic       sys_rst,
  output logic       cfg_rst_en,
  output logic       cfg_irq_en,
  output logic [3:0] cfg_sel
);
  localparam int CW       = BASE_EXP + NUM_SEL;
  localparam int WW       = $clog2(WIN_LEN + 1);
  localparam int MAX_CODE = NUM_SEL - 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [3:0]    sel_q;
  logic [WW-1:0] win_q;
  logic          rst_en_q, irq_en_q, flag_q, irq_q, srst_q;

  wire           win_open  = (win_q != '0);
  wire           rst_eff   = rst_en_q | fuse_lock;
  wire           irq_eff   = irq_en_q & ~fuse_lock;
  wire [3:0]     code      = (32'(sel_q) > MAX_CODE) ? 4'(MAX_CODE) : sel_q;
  wire [CW-1:0]  last_cnt  = (ONE << (BASE_EXP + 32'(code))) - ONE;
  wire           expire    = tick & ~kick & (cnt_q >= last_cnt);
  wire           unlock_wr = wr_en & wr_chg & wr_rst_en;
  wire           cfg_wr    = wr_en & ~wr_chg & win_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sel_q    <= '0;
      win_q    <= '0;
      rst_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      srst_q   <= 1'b0;
    end else begin
      irq_q  <= 1'b0;
      srst_q <= 1'b0;

      if (kick || expire)  cnt_q <= '0;
      else if (tick)       cnt_q <= cnt_q + ONE;

      if (unlock_wr)       win_q <= WW'(WIN_LEN);
      else if (cfg_wr)     win_q <= '0;
      else if (win_open)   win_q <= win_q - 1'b1;

      if (wr_en) begin
        irq_en_q <= wr_irq_en;
        if (wr_rst_en)     rst_en_q <= 1'b1;
        else if (cfg_wr)   rst_en_q <= 1'b0;
        if (cfg_wr)        sel_q <= wr_sel;
        if (wr_flag_clr)   flag_q <= 1'b0;
      end

      if (expire) begin
        if (irq_eff) begin
          flag_q <= 1'b1;
          irq_q  <= 1'b1;
          if (rst_eff) irq_en_q <= 1'b0;
        end else if (rst_eff) begin
          srst_q <= 1'b1;
        end
      end
    end
  end

  assign irq        = irq_q;
  assign irq_flag   = flag_q;
  assign sys_rst    = srst_q;
  assign cfg_rst_en = rst_eff;
  assign cfg_irq_en = irq_eff;
  assign cfg_sel    = sel_q;

  assert_rst_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);
  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && sys_rst));
  assert_kick_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!irq && !sys_rst));
  assert_escalate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(rst_eff)) |-> !cfg_irq_en);
  assert_fuse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_lock && $past(fuse_lock)) |-> !irq);
  assert_sel_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(win_open));
  assert_clear_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_en_q) |-> $past(win_open));
endmodule

// File: tb/sim_wdog_guard.sv
`timescale 1ns/1ps
module sim_wdog_guard;
  localparam int BASE = 3;
  localparam int NV = 13;
  localparam int VSEL [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12};
  localparam int VEXP [NV] = '{8, 16, 32, 64, 128, 256, 512, 1024, 2048,
                               4096, 4096, 4096, 4096};

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, kick = 0, fuse_lock = 0, wr_en = 0, wr_chg = 0;
  logic wr_rst_en = 0, wr_irq_en = 0, wr_flag_clr = 0;
  logic [3:0] wr_sel = '0;
  logic irq, irq_flag, sys_rst, cfg_rst_en, cfg_irq_en;
  logic [3:0] cfg_sel;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_guard #(.BASE_EXP(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .fuse_lock(fuse_lock),
    .wr_en(wr_en), .wr_chg(wr_chg), .wr_rst_en(wr_rst_en), .wr_irq_en(wr_irq_en),
    .wr_sel(wr_sel), .wr_flag_clr(wr_flag_clr), .irq(irq), .irq_flag(irq_flag),
    .sys_rst(sys_rst), .cfg_rst_en(cfg_rst_en), .cfg_irq_en(cfg_irq_en),
    .cfg_sel(cfg_sel));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit c, input bit re, input bit ie, input int s, input bit fc);
    wr_en = 1; wr_chg = c; wr_rst_en = re; wr_irq_en = ie; wr_sel = 4'(s); wr_flag_clr = fc;
    @(negedge clk);
    wr_en = 0; wr_chg = 0; wr_rst_en = 0; wr_irq_en = 0; wr_flag_clr = 0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // kick (optionally with a tick), then tick until irq or sys_rst appears
  task automatic measure(input bit with_tick, output int n, output bit gi, output bit gr);
    kick = 1; tick = with_tick;
    @(negedge clk);
    kick = 0; tick = 1; n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!irq && !sys_rst && n < 10000);
    gi = irq; gr = sys_rst;
    tick = 0;
  endtask

  initial begin
    #900000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n; bit gi, gr, seen;
    idle(3);
    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 flag", irq_flag, 0); chk("R1 sys_rst", sys_rst, 0);
    chk("R1 rst_en", cfg_rst_en, 0); chk("R1 irq_en", cfg_irq_en, 0); chk("R1 sel", cfg_sel, 0);
    rst_n = 1; idle(2);

    // R12 neither enable: 20 ticks through an 8-tick period
    seen = 0; tick = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (irq || sys_rst) seen = 1; end
    tick = 0;
    chk("R12 silent expiry", seen, 0);

    // R2 / R5 / R8 vector table walk
    for (int v = 0; v < NV; v++) begin
      wr(1, 1, 0, 0, 0);
      wr(0, 1, 0, VSEL[v], 0);
      chk("R8 sel load", cfg_sel, VSEL[v]);
      measure(0, n, gi, gr);
      chk("R2 period", n, VEXP[v]);
      chk("R5 reset pulse", gr, 1);
      chk("R5 flag untouched", irq_flag, 0);
      idle(1);
      chk("R5 pulse width", sys_rst, 0);
    end

    // R3 kick priority after a partial count
    wr(1, 1, 0, 0, 0); wr(0, 1, 0, 0, 0);
    kick = 1; @(negedge clk); kick = 0; tick = 1; idle(5); tick = 0;
    measure(1, n, gi, gr);
    chk("R3 kick wins over tick", n, 8);

    // R9 writes outside the window
    wr(0, 0, 0, 5, 0);
    chk("R9 clear ignored", cfg_rst_en, 1); chk("R9 sel ignored", cfg_sel, 0);
    wr(0, 1, 1, 0, 0);
    chk("R9 irq_en set", cfg_irq_en, 1);
    wr(0, 1, 0, 0, 0);
    chk("R9 irq_en clear", cfg_irq_en, 0);

    // R10 window expiry, R8 last cycle
    wr(1, 1, 0, 0, 0); idle(4); wr(0, 1, 0, 3, 0);
    chk("R10 late write", cfg_sel, 0);
    wr(1, 1, 0, 0, 0); idle(3); wr(0, 1, 0, 2, 0);
    chk("R8 fourth cycle", cfg_sel, 2);
    wr(1, 1, 0, 0, 0); wr(0, 1, 0, 0, 0);

    // R4 interrupt mode
    wr(1, 1, 0, 0, 0); wr(0, 0, 1, 0, 0);
    chk("R4 rst_en cleared", cfg_rst_en, 0); chk("R4 irq_en", cfg_irq_en, 1);
    measure(0, n, gi, gr);
    chk("R4 period", n, 8); chk("R4 irq", gi, 1); chk("R4 no reset", gr, 0);
    chk("R4 flag", irq_flag, 1);
    idle(1); chk("R4 irq width", irq, 0);
    measure(0, n, gi, gr);
    chk("R4 repeat", n, 8); chk("R4 repeat irq", gi, 1);
    wr(0, 0, 1, 0, 1);
    chk("R7 flag clear", irq_flag, 0);

    // R6 combined escalation
    wr(0, 1, 1, 0, 0);
    measure(0, n, gi, gr);
    chk("R6 first irq", gi, 1); chk("R6 first no reset", gr, 0); chk("R6 first period", n, 8);
    chk("R6 irq_en dropped", cfg_irq_en, 0);
    measure(0, n, gi, gr);
    chk("R6 then reset", gr, 1); chk("R6 no second irq", gi, 0); chk("R6 second period", n, 8);

    // R11 fuse
    wr(1, 1, 0, 0, 0); wr(0, 0, 0, 0, 0);
    chk("R11 pre-fuse rst_en", cfg_rst_en, 0);
    fuse_lock = 1; idle(1);
    chk("R11 rst_en forced", cfg_rst_en, 1);
    wr(0, 0, 1, 0, 0);
    chk("R11 irq_en blocked", cfg_irq_en, 0);
    measure(0, n, gi, gr);
    chk("R11 reset", gr, 1); chk("R11 no irq", gi, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule